// File: doc/BRIEF.md
# Secure-Aware Interrupt State Bitmaps

This block keeps three per-line state vectors for an interrupt distributor: an enable bit, a pending bit and an active bit for every implemented interrupt line. Software reaches them through a 32-bit register port. Each state vector has a pair of address windows, one that sets bits and one that clears them. Every access carries a security attribute. The written data, and the data read back, are gated by a per-word access mask. That mask is built from the security attribute, a global security-disable input, the line's group bit and a 2-bit non-secure permission field per line.

Interrupt wires enter the block as levels. A line configured as edge-triggered latches a pending bit when its level rises. A line configured as level-triggered latches nothing, but its current level is merged into every pending read. After each accepted register write, and after each change on an input line, the block raises a one-cycle update strobe. The strobe carries the first line number of the lowest affected register word, so that a downstream arbiter can re-evaluate that word. Arbitration and CPU signalling stay outside this block.

Top module: `irq_bitmap_bank`

## Requirements
- R1: The register address is 10 bits. Bits [9:7] pick a window: 0 sets enables, 1 clears enables, 2 sets pending, 3 clears pending, 4 sets active and 5 clears active. Bits [6:2] pick a word, and that word covers lines word*32 to word*32+31. Windows 6 and 7 read as 0 and ignore writes.
- R2: A word is out of range when it is word 0 (internal lines 0 to 31), when its first line is at or above NUM_IRQ, or when address bits [1:0] are not zero. Such a word reads as 0, ignores writes and raises no update strobe.
- R3: A set-window write ORs the masked data into the vector. A clear-window write clears each vector bit whose masked data bit is 1.
- R4: When the access is secure, or when sec_disable is 1, the mask is all ones. Otherwise the mask starts as the 32 group bits of the word.
- R5: Non-secure access is further widened by the per-line field nsac_bits[2n+1:2n]. In the set-pending window, a line is also reachable when its field is 1 or more. In the clear-pending window and both active windows, it is reachable when its field is 2 or more. In the enable windows the field is ignored.
- R6: A read of either pending window returns the stored pending bits ORed with (not edge_cfg AND the line level registered on the previous clock). The result is then masked.
- R7: A 0-to-1 change of irq_level on a line whose edge_cfg is 1 sets that line's pending bit on the clock edge where the new level is first sampled. An unchanged level, a falling level, or a rising level-triggered line stores nothing. A rise wins over a clear-pending write to the same line in the same cycle.
- R8: A read request returns rd_data with rd_valid high exactly one cycle later. rd_valid is low in every cycle that follows a cycle without a read request.
- R9: One cycle after an accepted write (windows 0 to 5, word in range), or after any change on an irq_level line, upd_valid is 1 for one cycle. upd_base then equals 32 times the lowest affected word.
- R10: Reset clears all three vectors, the level history, rd_valid and upd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address: window, word and byte offset |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access carries the secure attribute |
| sec_disable | input | 1 | Disables security masking globally |
| group_bits | input | NUM_IRQ | Group bit per line |
| edge_cfg | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| nsac_bits | input | 2*NUM_IRQ | Non-secure permission field, 2 bits per line |
| irq_level | input | NUM_IRQ | Interrupt wire levels |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| enable_q | output | NUM_IRQ | Enable vector |
| pend_q | output | NUM_IRQ | Stored pending vector |
| active_q | output | NUM_IRQ | Active vector |
| upd_valid | output | 1 | Update strobe |
| upd_base | output | clog2(NUM_IRQ) | First line of the lowest affected word |

## Verification
The masked write and read paths are driven with directed patterns, chosen so that each pattern isolates one mask source:
- Secure accesses need the all-ones mask.
- Non-secure accesses with half a word grouped show that the group bits alone gate enables.
- Permission fields of 1 and 2 on neighbouring lines show the different thresholds of the set-pending, clear-pending and active windows.

Level-triggered lines held high are read through both pending windows, which separates the stored bit from the merged live level. Edge lines are raised, held, and raised together with a clear-pending write, which fixes both the latch point and the rise-over-clear priority. Beyond these directed cases, a seeded random mix of windows, words (including the internal and unimplemented words), security settings, permission fields and level toggles is compared cycle by cycle against a bench model.

// File: rtl/irq_bitmap_pkg.sv
package irq_bitmap_pkg;

   localparam int LINES_PER_WORD = 32;
   localparam int INTERNAL_LINES = 32;
   localparam int REG_ADDR_W     = 10;

   typedef enum logic [2:0] {
      WIN_SET_EN = 3'd0,
      WIN_CLR_EN = 3'd1,
      WIN_SET_PD = 3'd2,
      WIN_CLR_PD = 3'd3,
      WIN_SET_AC = 3'd4,
      WIN_CLR_AC = 3'd5
   } win_e;

   typedef enum logic [1:0] {
      MK_GROUP_ONLY = 2'd0,
      MK_FIELD_GE1  = 2'd1,
      MK_FIELD_GE2  = 2'd2
   } mask_kind_e;

   function automatic mask_kind_e kind_of(input logic [2:0] win);
      case (win)
         3'd2:            return MK_FIELD_GE1;
         3'd3, 3'd4, 3'd5: return MK_FIELD_GE2;
         default:         return MK_GROUP_ONLY;
      endcase
   endfunction

endpackage

// File: rtl/irq_word_mask.sv
module irq_word_mask
   import irq_bitmap_pkg::*;
#(
   parameter int LINES = LINES_PER_WORD
) (
   input  logic               full_access,
   input  mask_kind_e         kind,
   input  logic [LINES-1:0]   grp,
   input  logic [2*LINES-1:0] fld,
   output logic [LINES-1:0]   mask
);

   for (genvar i = 0; i < LINES; i++) begin : g_bit
      logic extra;
      always_comb begin
         case (kind)
            MK_FIELD_GE1: extra = |fld[2*i +: 2];
            MK_FIELD_GE2: extra = fld[2*i+1];
            default:      extra = 1'b0;
         endcase
      end
      assign mask[i] = full_access | grp[i] | extra;
   end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level_in,
   input  logic [N-1:0] edge_cfg,
   output logic [N-1:0] level_q,
   output logic [N-1:0] rise,
   output logic [N-1:0] toggled
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= level_in;
   end

   assign rise    = level_in & ~level_q & edge_cfg;
   assign toggled = level_in ^ level_q;

endmodule

// File: rtl/irq_state_word.sv
module irq_state_word
   import irq_bitmap_pkg::*;
#(
   parameter int LINES = LINES_PER_WORD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [2:0]       win,
   input  logic [LINES-1:0] wbits,
   input  logic [LINES-1:0] rise,
   output logic [LINES-1:0] en_q,
   output logic [LINES-1:0] pd_q,
   output logic [LINES-1:0] ac_q
);

   logic [LINES-1:0] en_n, pd_n, ac_n;
   win_e wsel;

   assign wsel = win_e'(win);

   always_comb begin
      en_n = en_q;
      pd_n = pd_q;
      ac_n = ac_q;
      if (hit) begin
         case (wsel)
            WIN_SET_EN: en_n = en_q | wbits;
            WIN_CLR_EN: en_n = en_q & ~wbits;
            WIN_SET_PD: pd_n = pd_q | wbits;
            WIN_CLR_PD: pd_n = pd_q & ~wbits;
            WIN_SET_AC: ac_n = ac_q | wbits;
            WIN_CLR_AC: ac_n = ac_q & ~wbits;
            default: ;
         endcase
      end
      pd_n = pd_n | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         pd_q <= '0;
         ac_q <= '0;
      end else begin
         en_q <= en_n;
         pd_q <= pd_n;
         ac_q <= ac_n;
      end
   end

endmodule

// File: rtl/irq_bitmap_bank.sv
module irq_bitmap_bank
   import irq_bitmap_pkg::*;
#(
   parameter int NUM_IRQ = 96
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [REG_ADDR_W-1:0]      req_addr,
   input  logic [31:0]                req_wdata,
   input  logic                       req_secure,
   input  logic                       sec_disable,
   input  logic [NUM_IRQ-1:0]         group_bits,
   input  logic [NUM_IRQ-1:0]         edge_cfg,
   input  logic [2*NUM_IRQ-1:0]       nsac_bits,
   input  logic [NUM_IRQ-1:0]         irq_level,
   output logic                       rd_valid,
   output logic [31:0]                rd_data,
   output logic [NUM_IRQ-1:0]         enable_q,
   output logic [NUM_IRQ-1:0]         pend_q,
   output logic [NUM_IRQ-1:0]         active_q,
   output logic                       upd_valid,
   output logic [$clog2(NUM_IRQ)-1:0] upd_base
);

   localparam int NW     = NUM_IRQ / LINES_PER_WORD;
   localparam int INT_W  = INTERNAL_LINES / LINES_PER_WORD;
   localparam int WSEL_W = (NW > 1) ? $clog2(NW) : 1;
   localparam int BASE_W = $clog2(NUM_IRQ);

   if (NUM_IRQ % LINES_PER_WORD != 0) begin : g_bad_mult
      $error("NUM_IRQ must be a multiple of 32");
   end
   if (NUM_IRQ <= INTERNAL_LINES || NUM_IRQ > 1024) begin : g_bad_range
      $error("NUM_IRQ must lie in 64..1024");
   end

   logic [4:0]        acc_word;
   logic [2:0]        acc_win;
   logic              in_range, win_ok, wr_acc;
   logic [WSEL_W-1:0] sel_idx;

   assign acc_word = req_addr[6:2];
   assign acc_win  = req_addr[9:7];
   assign in_range = (int'(acc_word) >= INT_W) && (int'(acc_word) < NW) &&
                     (req_addr[1:0] == 2'b00);
   assign win_ok   = (acc_win <= 3'd5);
   assign sel_idx  = in_range ? WSEL_W'(acc_word) : '0;
   assign wr_acc   = req_valid && req_write && in_range && win_ok;

   logic [NUM_IRQ-1:0] lvl_q, rise_v, tog_v;

   irq_edge_detect #(.N(NUM_IRQ)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (irq_level),
      .edge_cfg (edge_cfg),
      .level_q  (lvl_q),
      .rise     (rise_v),
      .toggled  (tog_v)
   );

   logic [31:0] grp_w  [NW];
   logic [31:0] edge_w [NW];
   logic [31:0] lvl_w  [NW];
   logic [31:0] en_w   [NW];
   logic [31:0] pd_w   [NW];
   logic [31:0] ac_w   [NW];
   logic [63:0] nsac_w [NW];
   logic [NW-1:0] aff;

   for (genvar k = 0; k < NW; k++) begin : g_word
      logic hit;
      assign hit       = wr_acc && (sel_idx == WSEL_W'(k));
      assign grp_w[k]  = group_bits[k*32 +: 32];
      assign edge_w[k] = edge_cfg[k*32 +: 32];
      assign lvl_w[k]  = lvl_q[k*32 +: 32];
      assign nsac_w[k] = nsac_bits[k*64 +: 64];
      assign aff[k]    = hit || (|tog_v[k*32 +: 32]);

      irq_state_word #(.LINES(LINES_PER_WORD)) u_st (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (hit),
         .win   (acc_win),
         .wbits (req_wdata & acc_mask),
         .rise  (rise_v[k*32 +: 32]),
         .en_q  (en_w[k]),
         .pd_q  (pd_w[k]),
         .ac_q  (ac_w[k])
      );

      assign enable_q[k*32 +: 32] = en_w[k];
      assign pend_q[k*32 +: 32]   = pd_w[k];
      assign active_q[k*32 +: 32] = ac_w[k];
   end

   logic [31:0] acc_mask;

   irq_word_mask #(.LINES(LINES_PER_WORD)) u_mask (
      .full_access (req_secure | sec_disable),
      .kind        (kind_of(acc_win)),
      .grp         (grp_w[sel_idx]),
      .fld         (nsac_w[sel_idx]),
      .mask        (acc_mask)
   );

   logic [31:0] raw_rd;
   always_comb begin
      case (acc_win)
         3'd0, 3'd1: raw_rd = en_w[sel_idx];
         3'd2, 3'd3: raw_rd = pd_w[sel_idx] | (~edge_w[sel_idx] & lvl_w[sel_idx]);
         default:    raw_rd = ac_w[sel_idx];
      endcase
   end

   logic [BASE_W-1:0] base_n;
   always_comb begin
      base_n = '0;
      for (int k = NW - 1; k >= 0; k--) begin
         if (aff[k]) base_n = BASE_W'(k * LINES_PER_WORD);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         upd_valid <= 1'b0;
         upd_base  <= '0;
      end else begin
         rd_valid  <= req_valid && !req_write;
         if (req_valid && !req_write)
            rd_data <= (in_range && win_ok) ? (raw_rd & acc_mask) : 32'h0;
         upd_valid <= |aff;
         upd_base  <= base_n;
      end
   end

   // R2
   oor_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !in_range) |=> ($stable(enable_q) && $stable(active_q)));

   // R4
   ns_zero_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && in_range && acc_win == 3'd0 && !req_secure &&
       !sec_disable && grp_w[sel_idx] == 32'h0) |=> $stable(enable_q));

   // R7
   edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_v != '0) |=> ((pend_q & $past(rise_v)) == $past(rise_v)));

   // R8
   rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   // R9
   upd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> upd_valid);

endmodule

// File: tb/irq_bitmap_bank_tb.sv
`timescale 1ns/1ps
module irq_bitmap_bank_tb_top;

   localparam int N = 96;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_write, req_secure, sec_disable;
   logic [9:0]    req_addr;
   logic [31:0]   req_wdata;
   logic [N-1:0]  group_bits, edge_cfg, irq_level;
   logic [2*N-1:0] nsac_bits;
   logic          rd_valid, upd_valid;
   logic [31:0]   rd_data;
   logic [N-1:0]  enable_q, pend_q, active_q;
   logic [6:0]    upd_base;

   logic [N-1:0]  m_en, m_pd, m_ac, m_lvl;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   irq_bitmap_bank #(.NUM_IRQ(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
      .sec_disable(sec_disable), .group_bits(group_bits), .edge_cfg(edge_cfg),
      .nsac_bits(nsac_bits), .irq_level(irq_level), .rd_valid(rd_valid),
      .rd_data(rd_data), .enable_q(enable_q), .pend_q(pend_q),
      .active_q(active_q), .upd_valid(upd_valid), .upd_base(upd_base)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] f_mask(input int win, input int word, input bit sec);
      logic [31:0] m;
      if (sec || sec_disable) return 32'hFFFF_FFFF;
      for (int i = 0; i < 32; i++) begin
         logic [1:0] f;
         f = nsac_bits[(word*32+i)*2 +: 2];
         m[i] = group_bits[word*32+i];
         if (win == 2 && f >= 2'd1) m[i] = 1'b1;
         if ((win == 3 || win == 4 || win == 5) && f >= 2'd2) m[i] = 1'b1;
      end
      return m;
   endfunction

   // one clock: optional access plus new irq levels; checks everything after the edge
   task automatic step(input bit v, input bit w, input int win, input int word,
                       input logic [31:0] d, input bit sec, input logic [N-1:0] lv,
                       input string tag, input logic [1:0] boff = 2'b00);
      logic [31:0] mk, raw, exp_rd, wdm;
      logic [N-1:0] rise, tog;
      bit inr, ok, acc;
      logic [2:0] aff;
      int exp_base;
      inr = (word >= 1) && (word < N/32) && (boff == 2'b00);
      ok  = (win <= 5);
      mk  = (word < N/32) ? f_mask(win, word, sec) : 32'h0;
      raw = 32'h0;
      if (word < N/32) begin
         if (win <= 1) raw = m_en[word*32 +: 32];
         else if (win <= 3) raw = m_pd[word*32 +: 32] | (~edge_cfg[word*32 +: 32] & m_lvl[word*32 +: 32]);
         else raw = m_ac[word*32 +: 32];
      end
      exp_rd = (inr && ok) ? (raw & mk) : 32'h0;
      req_valid  = v;
      req_write  = w;
      req_addr   = {3'(win), 5'(word), boff};
      req_wdata  = d;
      req_secure = sec;
      irq_level  = lv;
      @(posedge clk);
      #1;
      acc = v && w && inr && ok;
      wdm = d & mk;
      if (acc) begin
         case (win)
            0: m_en[word*32 +: 32] = m_en[word*32 +: 32] | wdm;
            1: m_en[word*32 +: 32] = m_en[word*32 +: 32] & ~wdm;
            2: m_pd[word*32 +: 32] = m_pd[word*32 +: 32] | wdm;
            3: m_pd[word*32 +: 32] = m_pd[word*32 +: 32] & ~wdm;
            4: m_ac[word*32 +: 32] = m_ac[word*32 +: 32] | wdm;
            default: m_ac[word*32 +: 32] = m_ac[word*32 +: 32] & ~wdm;
         endcase
      end
      rise = lv & ~m_lvl & edge_cfg;
      tog  = lv ^ m_lvl;
      m_pd = m_pd | rise;
      m_lvl = lv;
      for (int k = 0; k < 3; k++) aff[k] = (acc && word == k) || (|tog[k*32 +: 32]);
      exp_base = 0;
      for (int k = 2; k >= 0; k--) if (aff[k]) exp_base = k * 32;
      req_valid = 1'b0;
      @(negedge clk);
      chk(rd_valid == (v && !w), "R8", "rd_valid", N'(rd_valid), N'(v && !w));
      if (v && !w) chk(rd_data == exp_rd, tag, "rd_data", N'(rd_data), N'(exp_rd));
      chk(upd_valid == (|aff), "R9", "upd_valid", N'(upd_valid), N'(|aff));
      if (|aff) chk(int'(upd_base) == exp_base, "R9", "upd_base", N'(upd_base), N'(exp_base));
      chk(enable_q == m_en, tag, "enable_q", enable_q, m_en);
      chk(pend_q == m_pd, tag, "pend_q", pend_q, m_pd);
      chk(active_q == m_ac, tag, "active_q", active_q, m_ac);
   endtask

   initial begin
      #(5ns * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [N-1:0] lv;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
      req_secure = 0; sec_disable = 0; group_bits = '0; edge_cfg = '0;
      nsac_bits = '0; irq_level = '0;
      m_en = '0; m_pd = '0; m_ac = '0; m_lvl = '0; lv = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk(enable_q == '0 && pend_q == '0 && active_q == '0, "R10", "vectors", enable_q | pend_q | active_q, '0);
      chk(!rd_valid && !upd_valid, "R10", "strobes", N'({rd_valid, upd_valid}), '0);

      // R3 secure set and clear
      step(1, 1, 0, 1, 32'hA5A5_0F0F, 1, lv, "R3");
      step(1, 1, 1, 1, 32'h0000_000F, 1, lv, "R3");
      step(1, 0, 1, 1, 32'h0, 1, lv, "R3");
      // R4 non-secure limited to group bits, then sec_disable opens all
      group_bits[63:32] = 32'h0000_FFFF;
      step(1, 1, 0, 1, 32'hFFFF_FFFF, 0, lv, "R4");
      step(1, 0, 0, 1, 32'h0, 0, lv, "R4");
      sec_disable = 1;
      step(1, 1, 0, 2, 32'hFFFF_FFFF, 0, lv, "R4");
      sec_disable = 0;
      // R5 permission fields: line 33 field 1, line 34 field 2, group 0
      group_bits = '0;
      nsac_bits[67:66] = 2'd1;
      nsac_bits[69:68] = 2'd2;
      step(1, 1, 2, 1, 32'hFFFF_FFFF, 0, lv, "R5");
      step(1, 0, 2, 1, 32'h0, 0, lv, "R5");
      step(1, 1, 3, 1, 32'hFFFF_FFFF, 0, lv, "R5");
      step(1, 1, 4, 1, 32'hFFFF_FFFF, 0, lv, "R5");
      step(1, 1, 0, 1, 32'hFFFF_FFFF, 0, lv, "R5");
      step(1, 0, 5, 1, 32'h0, 0, lv, "R5");
      // R2 out-of-range words and misaligned address; R1 unused windows
      step(1, 1, 0, 0, 32'hFFFF_FFFF, 1, lv, "R2");
      step(1, 1, 2, 3, 32'hFFFF_FFFF, 1, lv, "R2");
      step(1, 0, 0, 0, 32'h0, 1, lv, "R2");
      step(1, 1, 0, 2, 32'hFFFF_FFFF, 1, lv, "R2", 2'b10);
      step(1, 1, 6, 1, 32'hFFFF_FFFF, 1, lv, "R1");
      step(1, 0, 7, 1, 32'h0, 1, lv, "R1");
      // R6 level-triggered line 64 merged into pending reads
      edge_cfg[95:80] = 16'hFFFF;
      lv[64] = 1'b1;
      step(0, 0, 0, 0, 32'h0, 1, lv, "R6");
      step(1, 0, 2, 2, 32'h0, 1, lv, "R6");
      step(1, 0, 3, 2, 32'h0, 1, lv, "R6");
      // R7 edge line 80 rises, is held, and line 81 rises during a clear
      lv[80] = 1'b1;
      step(0, 0, 0, 0, 32'h0, 1, lv, "R7");
      step(1, 0, 2, 2, 32'h0, 1, lv, "R7");
      step(1, 1, 3, 2, 32'h0001_0000, 1, lv, "R7");
      step(0, 0, 0, 0, 32'h0, 1, lv, "R7");
      lv[81] = 1'b1;
      step(1, 1, 3, 2, 32'h0002_0000, 1, lv, "R7");
      lv[80] = 1'b0;
      step(0, 0, 0, 0, 32'h0, 1, lv, "R7");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int win, word;
         if ($urandom % 16 == 0) begin
            group_bits = {$urandom, $urandom, $urandom};
            nsac_bits  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            edge_cfg   = {$urandom, $urandom, $urandom};
            sec_disable = ($urandom % 4 == 0);
         end
         if ($urandom % 4 == 0) lv = lv ^ (N'(1) << ($urandom % N));
         win  = $urandom % 8;
         word = $urandom % 4;
         step($urandom % 4 != 0, $urandom % 2, win, word, $urandom, $urandom % 2, lv, "R3");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule